// File: doc/BRIEF.md
# Chained Barrel Issue Sequencer

This block decides, on every clock, which hardware thread slot of a barrel processor issues and what it issues. In the ordinary mode the slots take turns in a fixed rotation, and each slot presents its own instruction in its own turn. A slot can execute a chain-start instruction. After a fixed delay of one full rotation, the controller then copies every instruction from that slot, the initiator, onto each of the other slots in rotation order. Each copy runs against the register file of the slot that carries it and uses the initiator's memory-map selection. A chain-stop instruction from the initiator returns the machine to independent issue after one bubble cycle.

Fetch logic upstream presents a valid bit, an instruction word and two decoded flags (chain-start, chain-stop) for every slot. The sequencer returns a one-hot acknowledge that tells a slot's fetch unit to advance its program counter. Execution reports exceptions per slot. The sequencer re-addresses them, so that any exception raised while chained belongs to the initiator. The first exception in chained mode places the sequencer in a handler mode, in which the copies stop and only the initiator issues.

The states are NORM (independent rotation), ARM (chain-start seen, waiting for the initiator's next turn), CHAIN (replicating), HANDLER (exception taken, copies suspended) and DRAIN (one bubble after chain-stop). The transitions are:
- NORM→ARM on a valid chain-start.
- ARM→CHAIN when the rotation next reaches the initiator.
- CHAIN→HANDLER on any exception.
- CHAIN→DRAIN and HANDLER→DRAIN on a valid chain-stop issued by the initiator.
- DRAIN→NORM unconditionally.

Top module: `chain_issue_seq`

## Requirements
- R1: In NORM the issuing slot steps 0,1,…,NSLOT-1,0 one per clock. The issue outputs carry that slot's instruction, and the slot id, register-file select and memory-map select all equal the slot number. The control-flow permit `iss_ctl_own` is 1.
- R2: A slot whose valid bit is low in its turn gives a cycle with `iss_vld` low and no acknowledge. The rotation still advances to the next slot on the following clock.
- R3: A valid chain-start issued by slot i at cycle t leaves cycles t+1 to t+NSLOT-1 in normal independent issue. Replication starts with the initiator's own turn at cycle t+NSLOT.
- R4: In CHAIN the initiator issues its instruction in its own turn. The same word then issues on each following slot in rotation order, and `iss_slot` and `iss_rf` equal the carrying slot. If the initiator had no valid instruction, its copies are invalid too.
- R5: Every chained copy drives `iss_mm` with the initiator's slot number.
- R6: In CHAIN and HANDLER only the initiator's turn can raise an acknowledge, so the suspended slots' program counters are held. `slot_ack` is never more than one-hot.
- R7: `iss_ctl_own` is 0 on every chained copy, so only the initiator may take a branch.
- R8: A valid chain-stop issued by the initiator at cycle t is followed by one cycle with `iss_vld` low. Normal issue then resumes at cycle t+2 with the slot after the initiator.
- R9: While in CHAIN or HANDLER, any set bit of `exc_in` raises `exc_vld` with `exc_slot` equal to the initiator. From the next cycle on, copies stop and the non-initiator turns are idle until chain-stop.
- R10: A chain-start seen while in CHAIN and a chain-stop seen while in NORM have no effect on the issue sequence.
- R11: While reset is asserted `iss_vld` and `slot_ack` are 0. The first cycle after reset issues slot 0 in NORM.
- R12: Outside CHAIN and HANDLER, `exc_slot` is the lowest slot index whose `exc_in` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | NSLOT | Per-slot instruction available |
| slot_instr | input | NSLOT*IW | Per-slot instruction words, slot s at bits s*IW+:IW |
| dec_chain | input | NSLOT | Per-slot decoded chain-start flag |
| dec_unchain | input | NSLOT | Per-slot decoded chain-stop flag |
| exc_in | input | NSLOT | Per-slot exception raised by execution |
| iss_vld | output | 1 | An instruction issues this cycle |
| iss_slot | output | SW | Slot id carried with the instruction |
| iss_rf | output | SW | Register-file select |
| iss_mm | output | SW | Memory-map select |
| iss_instr | output | IW | Issued instruction word |
| iss_ctl_own | output | 1 | The issued instruction may redirect fetch |
| slot_ack | output | NSLOT | One-hot program-counter advance for the issuing slot |
| exc_vld | output | 1 | An exception is reported this cycle |
| exc_slot | output | SW | Slot that owns the reported exception |

## Verification
A wrong state register shows up within one rotation. A stale initiator index or replica word shows at the next copy turn as the wrong memory map or the wrong instruction word. A missed mode change shows as an acknowledge on a slot that should be suspended, or as a copy where independent issue was due. If the rotation pointer does not hold during the chain-stop bubble, every later slot id is off by one, so each cycle after resume exposes it. The sweep walks a fixed cycle script through every state and both wrap positions of the initiator, and compares every issue field each cycle with values derived from the cycle number.

// File: rtl/chain_seq_pkg.sv
package chain_seq_pkg;
    typedef enum logic [2:0] {
        ST_NORM    = 3'd0,
        ST_ARM     = 3'd1,
        ST_CHAIN   = 3'd2,
        ST_HANDLER = 3'd3,
        ST_DRAIN   = 3'd4
    } seq_state_e;
endpackage

// File: rtl/chain_rr_ptr.sv
module chain_rr_ptr #(
    parameter int NSLOT = 4,
    parameter int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [SW-1:0] ptr,
    output logic [SW-1:0] ptr_nxt
);
    localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

    assign ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= '0;
        else if (adv) ptr <= ptr_nxt;
    end

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr == LAST) |=> (ptr == '0)); // R1
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1)); // R1
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr)); // R8
endmodule

// File: rtl/chain_rep_reg.sv
module chain_rep_reg #(
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          clr,
    input  logic          d_vld,
    input  logic [IW-1:0] d_instr,
    output logic          q_vld,
    output logic [IW-1:0] q_instr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_vld   <= 1'b0;
            q_instr <= '0;
        end else if (clr) begin
            q_vld   <= 1'b0;
        end else if (load) begin
            q_vld   <= d_vld;
            q_instr <= d_instr;
        end
    end

    AST_REP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q_vld); // R9
endmodule

// File: rtl/chain_exc_map.sv
module chain_exc_map #(
    parameter int NSLOT = 4,
    parameter int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic [NSLOT-1:0] exc_in,
    input  logic             redirect,
    input  logic [SW-1:0]    init_slot,
    output logic             exc_vld,
    output logic [SW-1:0]    exc_slot
);
    logic [SW-1:0] low_idx;

    always_comb begin
        low_idx = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (exc_in[s]) low_idx = SW'(s);
        end
    end

    assign exc_vld  = |exc_in;
    assign exc_slot = redirect ? init_slot : low_idx;

    always_comb begin
        if (exc_vld && !redirect) begin
            AST_EXC_OWN: assert (exc_in[exc_slot]); // R12
        end
    end
endmodule

// File: rtl/chain_issue_seq.sv
module chain_issue_seq
    import chain_seq_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int IW    = 32,
    parameter int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSLOT-1:0]    slot_vld,
    input  logic [NSLOT*IW-1:0] slot_instr,
    input  logic [NSLOT-1:0]    dec_chain,
    input  logic [NSLOT-1:0]    dec_unchain,
    input  logic [NSLOT-1:0]    exc_in,
    output logic                iss_vld,
    output logic [SW-1:0]       iss_slot,
    output logic [SW-1:0]       iss_rf,
    output logic [SW-1:0]       iss_mm,
    output logic [IW-1:0]       iss_instr,
    output logic                iss_ctl_own,
    output logic [NSLOT-1:0]    slot_ack,
    output logic                exc_vld,
    output logic [SW-1:0]       exc_slot
);
    seq_state_e    st_q, st_d;
    logic [SW-1:0] ptr, ptr_nxt;
    logic [SW-1:0] init_q, init_d;
    logic          ptr_adv;
    logic          cur_vld, cur_chain, cur_unch, at_init;
    logic [IW-1:0] cur_instr;
    logic          rep_load, rep_clr, rep_vld;
    logic [IW-1:0] rep_instr;
    logic          chained, any_exc;
    logic          stop_now;

    assign cur_vld   = slot_vld[ptr];
    assign cur_chain = dec_chain[ptr];
    assign cur_unch  = dec_unchain[ptr];
    assign cur_instr = slot_instr[ptr*IW +: IW];
    assign at_init   = (ptr == init_q);
    assign chained   = (st_q == ST_CHAIN) || (st_q == ST_HANDLER);
    assign any_exc   = |exc_in;
    assign stop_now  = chained && at_init && cur_vld && cur_unch;
    assign ptr_adv   = (st_q != ST_DRAIN);
    assign rep_load  = (st_q == ST_CHAIN) && at_init;
    assign rep_clr   = (st_q != ST_CHAIN) || any_exc;

    chain_rr_ptr #(.NSLOT(NSLOT), .SW(SW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .adv(ptr_adv), .ptr(ptr), .ptr_nxt(ptr_nxt)
    );

    chain_rep_reg #(.IW(IW)) u_rep (
        .clk(clk), .rst_n(rst_n), .load(rep_load), .clr(rep_clr),
        .d_vld(cur_vld && !cur_unch), .d_instr(cur_instr),
        .q_vld(rep_vld), .q_instr(rep_instr)
    );

    chain_exc_map #(.NSLOT(NSLOT), .SW(SW)) u_exc (
        .exc_in(exc_in), .redirect(chained), .init_slot(init_q),
        .exc_vld(exc_vld), .exc_slot(exc_slot)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_NORM;
            init_q <= '0;
        end else begin
            st_q   <= st_d;
            init_q <= init_d;
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        init_d = init_q;
        unique case (st_q)
            ST_NORM: begin
                if (cur_vld && cur_chain) begin
                    st_d   = ST_ARM;
                    init_d = ptr;
                end
            end
            ST_ARM: begin
                if (ptr_nxt == init_q) st_d = ST_CHAIN;
            end
            ST_CHAIN: begin
                if (any_exc)       st_d = ST_HANDLER;
                else if (stop_now) st_d = ST_DRAIN;
            end
            ST_HANDLER: begin
                if (stop_now) st_d = ST_DRAIN;
            end
            ST_DRAIN: st_d = ST_NORM;
            default:  st_d = ST_NORM;
        endcase
    end

    // outputs
    always_comb begin
        iss_vld     = 1'b0;
        iss_slot    = ptr;
        iss_rf      = ptr;
        iss_mm      = ptr;
        iss_instr   = cur_instr;
        iss_ctl_own = 1'b1;
        slot_ack    = '0;
        unique case (st_q)
            ST_NORM, ST_ARM: begin
                iss_vld       = cur_vld;
                slot_ack[ptr] = cur_vld;
            end
            ST_CHAIN: begin
                iss_mm = init_q;
                if (at_init) begin
                    iss_vld       = cur_vld;
                    slot_ack[ptr] = cur_vld;
                end else begin
                    iss_vld     = rep_vld;
                    iss_instr   = rep_instr;
                    iss_ctl_own = 1'b0;
                end
            end
            ST_HANDLER: begin
                if (at_init) begin
                    iss_vld       = cur_vld;
                    slot_ack[ptr] = cur_vld;
                end
            end
            ST_DRAIN: iss_vld = 1'b0;
            default:  iss_vld = 1'b0;
        endcase
        if (!rst_n) begin
            iss_vld  = 1'b0;
            slot_ack = '0;
        end
    end

    always_comb begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (!iss_vld && slot_ack == '0); // R11
        end
    end

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_ack)); // R6
    AST_ACK_INIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (chained && slot_ack != '0) |-> slot_ack[init_q]); // R6
    AST_COPY_MM: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && !iss_ctl_own) |-> (iss_mm == init_q && iss_slot != init_q)); // R5
    AST_STOP_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_now |=> !iss_vld); // R8
    AST_HANDLER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CHAIN && any_exc) |=> (iss_ctl_own || !iss_vld)); // R9
endmodule

// File: tb/chain_issue_seq_bench.sv
module chain_issue_seq_bench;
    localparam int NSLOT = 4;
    localparam int IW    = 8;
    localparam int SW    = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NSLOT-1:0]    slot_vld = '0;
    logic [NSLOT*IW-1:0] slot_instr = '0;
    logic [NSLOT-1:0]    dec_chain = '0;
    logic [NSLOT-1:0]    dec_unchain = '0;
    logic [NSLOT-1:0]    exc_in = '0;
    logic                iss_vld;
    logic [SW-1:0]       iss_slot, iss_rf, iss_mm, exc_slot;
    logic [IW-1:0]       iss_instr;
    logic                iss_ctl_own, exc_vld;
    logic [NSLOT-1:0]    slot_ack;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    chain_issue_seq #(.NSLOT(NSLOT), .IW(IW)) u_chain_issue_seq (
        .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_instr(slot_instr),
        .dec_chain(dec_chain), .dec_unchain(dec_unchain), .exc_in(exc_in),
        .iss_vld(iss_vld), .iss_slot(iss_slot), .iss_rf(iss_rf), .iss_mm(iss_mm),
        .iss_instr(iss_instr), .iss_ctl_own(iss_ctl_own), .slot_ack(slot_ack),
        .exc_vld(exc_vld), .exc_slot(exc_slot)
    );

    task automatic chk(input bit ok, input string req, input int cyc,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    function automatic logic [3:0] vmask(input int c);
        return ((c >= 8 && c <= 11) || c == 25) ? 4'b1101 : 4'b1111;
    endfunction
    function automatic logic [3:0] cmask(input int c);
        return (c == 13 || c == 21) ? 4'b0010 : (c == 44) ? 4'b1000 : 4'b0000;
    endfunction
    function automatic logic [3:0] umask(input int c);
        return (c == 37) ? 4'b0010 : (c == 11 || c == 52) ? 4'b1000 : 4'b0000;
    endfunction
    function automatic logic [3:0] emask(input int c);
        return (c == 30) ? 4'b0100 : (c == 40) ? 4'b1000 : 4'b0000;
    endfunction

    task automatic drive(input int c);
        slot_vld    = vmask(c);
        dec_chain   = cmask(c);
        dec_unchain = umask(c);
        exc_in      = emask(c);
        for (int s = 0; s < NSLOT; s++)
            slot_instr[s*IW +: IW] = {4'(s), 4'(c)};
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        slot_vld = '1;
        repeat (3) @(negedge clk);
        #2;
        chk(!iss_vld, "R11 reset vld", -1, iss_vld, 0);
        chk(slot_ack == 0, "R11 reset ack", -1, slot_ack, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 56; c++) begin
            int  p, init, lead;
            bit  ev, own, copy, idle;
            int  eslot, emm, einstr;
            if (c > 0) @(negedge clk);
            drive(c);
            #2;
            p = (c < 38) ? c % 4 : (c < 54) ? (c - 1) % 4 : (c - 2) % 4;
            init = (c <= 38) ? 1 : 3;
            copy = 1'b0; idle = 1'b0; own = 1'b1;
            if (c == 38 || c == 53) idle = 1'b1;
            else if ((c >= 17 && c <= 30) || (c >= 48 && c <= 52))
                copy = (p != init);
            else if (c >= 31 && c <= 37)
                idle = (p != init);
            if (idle) begin
                chk(!iss_vld, "R8/R9 idle turn", c, iss_vld, 0);
                chk(slot_ack == 0, "R6 idle ack", c, slot_ack, 0);
            end else if (copy) begin
                lead = c - ((p + 4 - init) % 4);
                ev   = vmask(lead)[init] && !umask(lead)[init];
                chk(iss_vld == ev, "R4 copy valid", c, iss_vld, ev);
                if (ev) begin
                    einstr = {4'(init), 4'(lead)};
                    chk(iss_instr == IW'(einstr), "R4 copy word", c, iss_instr, einstr);
                    chk(iss_slot == SW'(p) && iss_rf == SW'(p), "R4 copy rf", c, iss_rf, p);
                    chk(iss_mm == SW'(init), "R5 copy mm", c, iss_mm, init);
                    chk(!iss_ctl_own, "R7 copy branch", c, iss_ctl_own, 0);
                end
                chk(slot_ack == 0, "R6 suspended ack", c, slot_ack, 0);
            end else begin
                ev     = vmask(c)[p];
                einstr = {4'(p), 4'(c)};
                emm    = ((c >= 17 && c <= 30) || (c >= 48 && c <= 52)) ? init : p;
                chk(iss_vld == ev, ev ? "R1 own valid" : "R2 idle slot", c, iss_vld, ev);
                if (ev) begin
                    chk(iss_slot == SW'(p) && iss_rf == SW'(p),
                        (c >= 14 && c <= 16) || (c >= 45 && c <= 47) ? "R3 arm window slot" :
                        (c == 39) ? "R8 resume slot" : (c == 0) ? "R11 first slot" :
                        (c == 12) ? "R10 unchain ignored" : (c == 22) ? "R10 chain ignored" :
                        "R1 slot", c, iss_slot, p);
                    chk(iss_instr == IW'(einstr), "R1 word", c, iss_instr, einstr);
                    chk(iss_mm == SW'(emm), "R5 init mm", c, iss_mm, emm);
                    chk(iss_ctl_own == own, "R7 own branch", c, iss_ctl_own, 1);
                    chk(slot_ack == 4'(1 << p), "R6 ack", c, slot_ack, 1 << p);
                end else begin
                    chk(slot_ack == 0, "R2 idle ack", c, slot_ack, 0);
                end
            end
            if (emask(c) != 0) begin
                eslot = (c == 30) ? 1 : 3;
                chk(exc_vld, "R9/R12 exc vld", c, exc_vld, 1);
                chk(exc_slot == SW'(eslot), c == 30 ? "R9 exc redirect" : "R12 exc own",
                    c, exc_slot, eslot);
            end else begin
                chk(!exc_vld, "R12 no exc", c, exc_vld, 0);
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule